// File: doc/BRIEF.md
# Branch and Next-PC Unit with Delay Slot

This block decides where instruction fetch goes next in a 32-bit fixed-format RISC pipeline whose control transfers have one delay slot. Each cycle it receives the program counter of the instruction being resolved, a 4-bit transfer kind from the decoder, two register operands, the 16-bit branch offset and the 26-bit jump field. It returns a registered next fetch address, and for jump-and-link it also returns a one-cycle write enable and the return address bound for register 31.

There are no condition codes. A branch either tests two registers for equality or inequality, or tests one register as a signed number against zero. When a transfer is taken, the redirect does not happen at once. The block first lets the sequential instruction through, which is the delay slot. It keeps the target in a pending register and switches fetch to that target one cycle later.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next edge shows `next_pc` equal to the reset vector (0), `link_we` low and `link_val` 0, and no redirect is pending.
- R2: Kind 1 (equal branch) is taken exactly when `rs_val == rt_val`. Kind 2 (not-equal branch) is taken exactly when they differ.
- R3: Kinds 3, 4, 5 and 6 compare `rs_val` alone, as a signed value, against zero. They are taken on <= 0, > 0, < 0 and >= 0 respectively. `rt_val` has no effect on them.
- R4: The target of kinds 1 to 6 is `pc + 4 + (sign-extended offset << 2)`.
- R5: Kinds 7 (jump) and 8 (jump-and-link) are always taken. Their target is `pc+4` bits [31:28] followed by the 26-bit field and then two zero bits.
- R6: Kind 8 drives `link_we` high for one cycle, with `link_val = pc + 4`. No other kind drives `link_we`, and `link_val` holds its value between links.
- R7: Kind 9 (jump-register) is always taken, and its target is `rs_val`.
- R8: In the cycle after a taken transfer, `next_pc` is `pc + 4`, which is the delay slot. In the cycle after that, `next_pc` is the saved target.
- R9: Kind 0, kinds 10 to 15, and branches that are not taken give `next_pc = pc + 4` and no link write.
- R10: While a redirect is pending, the kind presented in the delay slot has no effect. It starts no new transfer and writes no link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 32 | Address of the instruction being resolved |
| kind | input | 4 | Transfer kind (encoding in R2 to R9) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_off | input | 16 | Branch word offset |
| jmp_field | input | 26 | Jump word index |
| next_pc | output | 32 | Registered next fetch address |
| link_we | output | 1 | Registered write enable for register 31 |
| link_val | output | 32 | Registered return address |

## Verification
Every output is registered once. The result for the inputs presented before an edge can therefore be read just after that edge. The bench drives inputs on the falling edge and compares outputs on the next falling edge. The redirect for a taken transfer is due two edges after the transfer is presented, with the delay-slot input in between. The bench's reference model keeps its own pending flag and target so that it predicts that second edge independently.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [3:0] {
    XF_NONE = 4'd0,
    XF_EQ   = 4'd1,
    XF_NE   = 4'd2,
    XF_LEZ  = 4'd3,
    XF_GTZ  = 4'd4,
    XF_LTZ  = 4'd5,
    XF_GEZ  = 4'd6,
    XF_JMP  = 4'd7,
    XF_JAL  = 4'd8,
    XF_JREG = 4'd9
  } xfer_e;

  localparam int KIND_W = 4;
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic              taken,
  output logic              is_link
);
  logic  neg, zero;
  xfer_e k;

  assign k    = xfer_e'(kind);
  assign neg  = opa[XLEN-1];
  assign zero = (opa == '0);

  always_comb begin
    taken   = 1'b0;
    is_link = 1'b0;
    case (k)
      XF_EQ:   taken = (opa == opb);
      XF_NE:   taken = (opa != opb);
      XF_LEZ:  taken = neg | zero;
      XF_GTZ:  taken = ~neg & ~zero;
      XF_LTZ:  taken = neg;
      XF_GEZ:  taken = ~neg;
      XF_JMP:  taken = 1'b1;
      XF_JAL:  begin taken = 1'b1; is_link = 1'b1; end
      XF_JREG: taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int JFW  = 26
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   opa,
  input  logic [OFFW-1:0]   off,
  input  logic [JFW-1:0]    jfield,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   target
);
  localparam int SXW = XLEN - OFFW - 2;
  localparam int HIW = XLEN - JFW - 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] br_tgt, jp_tgt;
  xfer_e k;

  assign k      = xfer_e'(kind);
  assign seq_pc = pc + STEP;
  assign br_tgt = seq_pc + {{SXW{off[OFFW-1]}}, off, 2'b00};
  assign jp_tgt = {seq_pc[XLEN-1 -: HIW], jfield, 2'b00};

  always_comb begin
    case (k)
      XF_JMP, XF_JAL: target = jp_tgt;
      XF_JREG:        target = opa;
      default:        target = br_tgt;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              OFFW      = 16,
  parameter int              JFW       = 26,
  parameter logic [XLEN-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   pc,
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  input  logic [OFFW-1:0]   br_off,
  input  logic [JFW-1:0]    jmp_field,
  output logic [XLEN-1:0]   next_pc,
  output logic              link_we,
  output logic [XLEN-1:0]   link_val
);
  logic            taken, is_link;
  logic [XLEN-1:0] seq_pc, target;
  logic            pend_q;
  logic [XLEN-1:0] tgt_q, npc_q, link_q;
  logic            lwe_q;

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind(kind), .opa(rs_val), .opb(rt_val),
    .taken(taken), .is_link(is_link)
  );

  npc_target #(.XLEN(XLEN), .OFFW(OFFW), .JFW(JFW)) u_tgt (
    .kind(kind), .pc(pc), .opa(rs_val), .off(br_off), .jfield(jmp_field),
    .seq_pc(seq_pc), .target(target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      tgt_q  <= RESET_VEC;
      npc_q  <= RESET_VEC;
      lwe_q  <= 1'b0;
      link_q <= '0;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      npc_q  <= tgt_q;
      lwe_q  <= 1'b0;
    end else begin
      npc_q  <= seq_pc;
      pend_q <= taken;
      lwe_q  <= is_link;
      if (taken)   tgt_q  <= target;
      if (is_link) link_q <= seq_pc;
    end
  end

  assign next_pc  = npc_q;
  assign link_we  = lwe_q;
  assign link_val = link_q;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (next_pc == RESET_VEC && !link_we && !pend_q)); // R1
  AST_SLOT_SEQ: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && taken) |=> (next_pc == $past(pc) + XLEN'(4))); // R8
  AST_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> (next_pc == $past(tgt_q) && !pend_q)); // R8
  AST_SLOT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    pend_q |=> !link_we); // R10
  AST_LINK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    link_we |-> ($past(kind) == KIND_W'(XF_JAL) && !$past(pend_q)
                 && link_val == $past(pc) + XLEN'(4))); // R6
  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !link_we |=> (link_we || $stable(link_val))); // R6
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
  logic [3:0]  kind = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] next_pc, link_val;
  logic        link_we;

  int checks = 0;
  int fails  = 0;

  bit          m_pend = 0;
  logic [31:0] m_tgt  = '0;
  logic [31:0] m_link = '0;

  always #5 clk = ~clk;

  npc_unit dut (
    .clk(clk), .rst(rst), .pc(pc), .kind(kind), .rs_val(rs_val),
    .rt_val(rt_val), .br_off(br_off), .jmp_field(jmp_field),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  function automatic bit ref_taken(input [3:0] k, input [31:0] a, input [31:0] b);
    case (k)
      4'd1: return a == b;
      4'd2: return a != b;
      4'd3: return $signed(a) <= 0;
      4'd4: return $signed(a) > 0;
      4'd5: return $signed(a) < 0;
      4'd6: return $signed(a) >= 0;
      4'd7, 4'd8, 4'd9: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic [31:0] ref_target(input [3:0] k, input [31:0] p, input [31:0] a,
                                       input [15:0] o, input [25:0] j);
    logic [31:0] nxt;
    nxt = p + 32'd4;
    if (k == 4'd7 || k == 4'd8) return {nxt[31:28], j, 2'b00};
    if (k == 4'd9) return a;
    return nxt + (32'($signed(o)) * 4);
  endfunction

  function automatic string tag_of(input bit pend, input [3:0] k);
    if (pend) return "R8/R10";
    case (k)
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5, 4'd6: return "R3/R4";
      4'd7: return "R5";
      4'd8: return "R5/R6";
      4'd9: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check32(input string tag, input string what, input [31:0] act, input [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input [3:0] k, input [31:0] p, input [31:0] a, input [31:0] b,
                      input [15:0] o, input [25:0] j);
    logic [31:0] e_npc;
    bit          e_we, was_pend;
    string       tag;
    was_pend = m_pend;
    tag = tag_of(was_pend, k);
    if (m_pend) begin
      e_npc = m_tgt; e_we = 0; m_pend = 0;
    end else begin
      e_npc = p + 32'd4;
      e_we = (k == 4'd8);
      if (ref_taken(k, a, b)) begin
        m_pend = 1;
        m_tgt = ref_target(k, p, a, o, j);
      end
      if (e_we) m_link = p + 32'd4;
    end
    pc = p; kind = k; rs_val = a; rt_val = b; br_off = o; jmp_field = j;
    @(posedge clk);
    @(negedge clk);
    check32(tag, "next_pc", next_pc, e_npc);
    check32(tag, "link_we", {31'd0, link_we}, {31'd0, e_we});
    check32("R6", "link_val", link_val, m_link);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pend = 0; m_link = '0; m_tgt = '0;
    check32("R1", "reset next_pc", next_pc, 32'd0);
    check32("R1", "reset link_we", {31'd0, link_we}, 32'd0);
    check32("R1", "reset link_val", link_val, 32'd0);
  endtask

  function automatic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'd1;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    // R2 equal and not-equal, both outcomes
    step(4'd1, 32'h100, 32'd5, 32'd5, 16'd3, '0);
    step(4'd0, 32'h104, 0, 0, 0, 0);            // delay slot
    step(4'd0, 32'h200, 0, 0, 0, 0);            // redirect 0x104+12
    step(4'd2, 32'h300, 32'd5, 32'd5, 16'd3, '0); // R2 not taken
    // R3 signed compares at the edges
    step(4'd3, 32'h400, 32'd0, 32'd9, 16'hFFFF, '0);
    step(4'd0, 32'h404, 0, 0, 0, 0);
    step(4'd0, 32'h500, 0, 0, 0, 0);
    step(4'd4, 32'h600, 32'd0, 32'd0, 16'd1, '0);  // not taken at zero
    step(4'd5, 32'h700, 32'h8000_0000, 0, 16'h8000, '0); // R4 most negative offset
    step(4'd0, 32'h704, 0, 0, 0, 0);
    step(4'd0, 32'h800, 0, 0, 0, 0);
    step(4'd6, 32'h900, 32'h7FFF_FFFF, 0, 16'h7FFF, '0);
    step(4'd0, 32'h904, 0, 0, 0, 0);
    step(4'd0, 32'hA00, 0, 0, 0, 0);
    // R5 jump keeps upper bits of pc+4 (carry into bit 28)
    step(4'd7, 32'hAFFF_FFFC, 0, 0, 0, 26'h3FF_FFFF);
    step(4'd0, 32'hB000_0000, 0, 0, 0, 0);
    step(4'd0, 32'h1000, 0, 0, 0, 0);
    // R6 link, R10 branch in delay slot ignored
    step(4'd8, 32'h2000, 0, 0, 0, 26'h12_3456);
    step(4'd8, 32'h2004, 32'd1, 32'd1, 0, 26'h1);
    step(4'd0, 32'h3000, 0, 0, 0, 0);
    // R7 register jump, R9 unused code
    step(4'd9, 32'h4000, 32'hDEAD_BEE0, 0, 0, 0);
    step(4'd12, 32'h4004, 32'd0, 32'd0, 16'd4, '0);
    step(4'd12, 32'h5000, 32'd0, 32'd0, 16'd4, '0);
    // R1 reset drops a pending redirect
    step(4'd7, 32'h6000, 0, 0, 0, 26'h55);
    do_reset();
    step(4'd0, 32'h6100, 0, 0, 0, 0);
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      a = pick_val();
      b = ($urandom % 3 == 0) ? a : pick_val();
      step(4'($urandom % 12), $urandom & 32'hFFFF_FFFC, a, b,
           16'($urandom), 26'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule